// File: doc/BRIEF.md
# Memory Tag Granule Checker

This block decides whether a memory access may proceed under memory tagging. A 64-bit pointer carries a 4-bit tag in bits [59:56]. Every 16-byte granule the access touches has its own 4-bit tag held in a separate tag memory. The access passes only when each granule's tag equals the pointer's tag. The tag memory packs two granule tags into each byte, so one read covers a pair of neighbouring granules. The checker walks these bytes through a synchronous read port with one-cycle latency and reads at most one byte per cycle.

A `start` pulse launches a check. The check ends with a one-cycle `done` pulse, which carries the `pass` result and, on failure, the fault address. Some accesses are unchecked and pass at once without reading tag memory: the page is not tagged, tagging is turned off for the address half chosen by bit 55, or the pointer carries the match-all tag for that half. Each access stays inside one page and spans at most 2^SIZE_W bytes.

The controller has two states. In `S_IDLE` it waits for `start`. An unchecked start stays in `S_IDLE` and reports a pass on the next cycle. A checked start issues the first read and moves to `S_WAIT`. In `S_WAIT` the returned byte is evaluated. A mismatch returns the controller to `S_IDLE` with a fail, and so does reaching the granule count, with a pass. Otherwise the controller stays in `S_WAIT` and reads the next byte.

Top module: `tchk_top`

## Requirements
- R1: After reset `done`, `pass` and `tm_re` are 0 and the checker is idle.
- R2: A checked start reads tag byte address `ptr[TAG_AW+4:5]` in the same cycle. Each further read is to the next byte address, one read per cycle.
- R3: In a tag byte, bits [3:0] hold the tag of the granule whose address bit 4 is 0, and bits [7:4] hold the tag of the granule whose bit 4 is 1.
- R4: The number of granules checked is `(floor((ptr+size_m1)/16) - floor(ptr/16)) + 1`. Granules outside this range never cause a failure.
- R5: When `ptr[4]` is 1, checking starts on the high nibble of the first byte, and the low nibble of that byte is ignored.
- R6: Checking stops at the first mismatching granule, and no further bytes are read.
- R7: On failure at granule index 0 the fault address equals `ptr`. At index n>0 it equals `floor(ptr/16)*16 + 16*n`. On a pass the fault address is 0.
- R8: When `page_tagged` is 0 the check passes, and no tag byte is read.
- R9: When `tbi_en[ptr[55]]` is 0 the check passes, and no tag byte is read.
- R10: When `match_all_en[ptr[55]]` is 1, the check passes with no read if the pointer tag is 4'h0 (for `ptr[55]`=0) or 4'hF (for `ptr[55]`=1). Any other tag is checked normally.
- R11: `done` is a one-cycle pulse. It comes one cycle after `start` for an unchecked access, and one cycle after the last read data for a checked access.
- R12: A `start` pulse that arrives while a check is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a check with the inputs below |
| ptr | input | ADDR_W | Access pointer, tag in [59:56], half select in [55] |
| size_m1 | input | SIZE_W | Access size in bytes minus one |
| page_tagged | input | 1 | Access page holds tagged memory |
| tbi_en | input | 2 | Top-byte tagging enable per address half |
| match_all_en | input | 2 | Match-all tag enable per address half |
| tm_re | output | 1 | Tag memory read enable |
| tm_addr | output | TAG_AW | Tag memory byte address |
| tm_rdata | input | 8 | Tag byte, valid one cycle after `tm_re` |
| done | output | 1 | Result valid pulse |
| pass | output | 1 | Check passed |
| fault_addr | output | ADDR_W | Address of first failing byte or granule |

## Verification
The bench builds the checker with TAG_AW = 8 and SIZE_W = 8. This gives an 8 KB tagged window, 256 bytes of tag memory, and a largest access of 256 bytes. An unaligned 256-byte access therefore spans 17 granules and nine tag bytes, which exercises the full granule counter and both nibble start parities. The window also lets a mismatch be placed just past the end of an access, and lets one access place several mismatches, so the bench can confirm that only the first one is reported.

// File: rtl/tchk_pkg.sv
package tchk_pkg;
    localparam int TAG_W    = 4;
    localparam int GRAN_LG  = 4;
    localparam int TAG_LSB  = 56;
    localparam int HALF_BIT = 55;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } tchk_state_e;
endpackage

// File: rtl/tchk_scope.sv
module tchk_scope
    import tchk_pkg::*;
(
    input  logic [TAG_W-1:0] ptr_tag,
    input  logic             half,
    input  logic             page_tagged,
    input  logic [1:0]       tbi_en,
    input  logic [1:0]       match_all_en,
    output logic             skip
);
    logic [TAG_W-1:0] match_val;
    logic             tbi_off;
    logic             match_hit;

    always_comb begin
        match_val = half ? {TAG_W{1'b1}} : {TAG_W{1'b0}};
        tbi_off   = !tbi_en[half];
        match_hit = match_all_en[half] && (ptr_tag == match_val);
        skip      = tbi_off || match_hit || !page_tagged;
    end
endmodule

// File: rtl/tchk_span.sv
module tchk_span
    import tchk_pkg::*;
#(
    parameter int SIZE_W = 8,
    localparam int CNT_W = SIZE_W + 2 - GRAN_LG
) (
    input  logic [SIZE_W:0]   ptr_lo,
    input  logic [SIZE_W-1:0] size_m1,
    output logic [CNT_W-1:0]  gran_count,
    output logic              odd_start
);
    logic [SIZE_W+1:0] lo_start;
    logic [SIZE_W+1:0] lo_end;

    always_comb begin
        lo_start   = {1'b0, ptr_lo};
        lo_end     = lo_start + {2'b00, size_m1};
        gran_count = lo_end[SIZE_W+1:GRAN_LG] - lo_start[SIZE_W+1:GRAN_LG]
                   + CNT_W'(1);
        odd_start  = ptr_lo[GRAN_LG];
    end
endmodule

// File: rtl/tchk_nib_eval.sv
module tchk_nib_eval
    import tchk_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [2*TAG_W-1:0] tag_byte,
    input  logic [TAG_W-1:0]   ptr_tag,
    input  logic               odd,
    input  logic [CNT_W-1:0]   n_done,
    input  logic [CNT_W-1:0]   count,
    output logic               fail,
    output logic [CNT_W-1:0]   fail_idx,
    output logic               finish_ok,
    output logic [CNT_W-1:0]   n_next
);
    logic [2*TAG_W-1:0] diff;
    logic               lo_bad;
    logic               hi_bad;
    logic [CNT_W-1:0]   n_one;
    logic [CNT_W-1:0]   n_two;

    always_comb begin
        diff      = tag_byte ^ {ptr_tag, ptr_tag};
        lo_bad    = |diff[TAG_W-1:0];
        hi_bad    = |diff[2*TAG_W-1:TAG_W];
        n_one     = n_done + CNT_W'(1);
        n_two     = n_done + CNT_W'(2);
        fail      = 1'b0;
        fail_idx  = n_done;
        finish_ok = 1'b0;
        n_next    = n_two;
        if (odd) begin
            n_next = n_one;
            if (hi_bad) begin
                fail = 1'b1;
            end else begin
                finish_ok = (n_one == count);
            end
        end else if (lo_bad) begin
            fail = 1'b1;
        end else if (n_one == count) begin
            finish_ok = 1'b1;
        end else if (hi_bad) begin
            fail     = 1'b1;
            fail_idx = n_one;
        end else begin
            finish_ok = (n_two == count);
        end
    end
endmodule

// File: rtl/tchk_top.sv
module tchk_top
    import tchk_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int TAG_AW = 10,
    parameter int SIZE_W = 8,
    localparam int CNT_W = SIZE_W + 2 - GRAN_LG,
    localparam int BYTE_LSB = GRAN_LG + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [SIZE_W-1:0] size_m1,
    input  logic              page_tagged,
    input  logic [1:0]        tbi_en,
    input  logic [1:0]        match_all_en,
    output logic              tm_re,
    output logic [TAG_AW-1:0] tm_addr,
    input  logic [7:0]        tm_rdata,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fault_addr
);
    tchk_state_e       state;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  n_q;
    logic              odd_q;
    logic [TAG_AW-1:0] baddr_q;

    logic              skip;
    logic [CNT_W-1:0]  gran_count;
    logic              odd_start;
    logic              ev_fail;
    logic [CNT_W-1:0]  ev_fail_idx;
    logic              ev_finish;
    logic [CNT_W-1:0]  ev_n_next;
    logic              launch;
    logic              step_on;
    logic [ADDR_W-1:0] fault_calc;

    tchk_scope u_scope (
        .ptr_tag      (ptr[TAG_LSB +: TAG_W]),
        .half         (ptr[HALF_BIT]),
        .page_tagged  (page_tagged),
        .tbi_en       (tbi_en),
        .match_all_en (match_all_en),
        .skip         (skip)
    );

    tchk_span #(.SIZE_W(SIZE_W)) u_span (
        .ptr_lo     (ptr[SIZE_W:0]),
        .size_m1    (size_m1),
        .gran_count (gran_count),
        .odd_start  (odd_start)
    );

    tchk_nib_eval #(.CNT_W(CNT_W)) u_eval (
        .tag_byte  (tm_rdata),
        .ptr_tag   (ptr_q[TAG_LSB +: TAG_W]),
        .odd       (odd_q),
        .n_done    (n_q),
        .count     (count_q),
        .fail      (ev_fail),
        .fail_idx  (ev_fail_idx),
        .finish_ok (ev_finish),
        .n_next    (ev_n_next)
    );

    always_comb begin
        launch  = (state == S_IDLE) && start && !skip;
        step_on = (state == S_WAIT) && !ev_fail && !ev_finish;
        tm_re   = launch || step_on;
        unique case (state)
            S_IDLE: tm_addr = ptr[BYTE_LSB +: TAG_AW];
            S_WAIT: tm_addr = baddr_q + TAG_AW'(1);
            default: tm_addr = baddr_q;
        endcase
        if (ev_fail_idx == '0) begin
            fault_calc = ptr_q;
        end else begin
            fault_calc = {ptr_q[ADDR_W-1:GRAN_LG]
                          + (ADDR_W-GRAN_LG)'(ev_fail_idx), {GRAN_LG{1'b0}}};
        end
    end

    // State register and walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            ptr_q   <= '0;
            count_q <= '0;
            n_q     <= '0;
            odd_q   <= 1'b0;
            baddr_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (launch) begin
                        state   <= S_WAIT;
                        ptr_q   <= ptr;
                        count_q <= gran_count;
                        n_q     <= '0;
                        odd_q   <= odd_start;
                        baddr_q <= ptr[BYTE_LSB +: TAG_AW];
                    end
                end
                S_WAIT: begin
                    if (ev_fail || ev_finish) begin
                        state <= S_IDLE;
                    end else begin
                        n_q     <= ev_n_next;
                        odd_q   <= 1'b0;
                        baddr_q <= baddr_q + TAG_AW'(1);
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            pass       <= 1'b0;
            fault_addr <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start && skip) begin
                        done       <= 1'b1;
                        pass       <= 1'b1;
                        fault_addr <= '0;
                    end
                end
                S_WAIT: begin
                    if (ev_fail) begin
                        done       <= 1'b1;
                        pass       <= 1'b0;
                        fault_addr <= fault_calc;
                    end else if (ev_finish) begin
                        done       <= 1'b1;
                        pass       <= 1'b1;
                        fault_addr <= '0;
                    end
                end
                default: done <= 1'b0;
            endcase
        end
    end

    // R11: result is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: every read is followed by a cycle in which the data is evaluated
    a_r2_read_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
        tm_re |=> (state == S_WAIT));

    // R2: back-to-back reads walk consecutive byte addresses
    a_r2_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_re && $past(tm_re)) |-> (tm_addr == TAG_AW'($past(tm_addr) + 1'b1)));

    // R8: an untagged page never triggers a read
    a_r8_untagged_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_IDLE) && start && !page_tagged) |-> !tm_re);

    // R7: a fault is either the pointer or a later granule base
    a_r7_fault_form: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> ((fault_addr == ptr_q) ||
            ((fault_addr[GRAN_LG-1:0] == '0) && (fault_addr > ptr_q))));

    // R12: no new walk may begin while one is running
    a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_WAIT) && start && !tm_re) |=> $stable(ptr_q));
endmodule

// File: tb/tchk_top_tb.sv
`timescale 1ns/1ps
module tchk_top_tb;
    localparam int TAG_AW = 8;
    localparam int SIZE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [63:0]       ptr = '0;
    logic [SIZE_W-1:0] size_m1 = '0;
    logic              page_tagged = 1'b0;
    logic [1:0]        tbi_en = 2'b11;
    logic [1:0]        match_all_en = 2'b00;
    logic              tm_re;
    logic [TAG_AW-1:0] tm_addr;
    logic [7:0]        tm_rdata = '0;
    logic              done;
    logic              pass;
    logic [63:0]       fault_addr;

    logic [7:0] tmem [1 << TAG_AW];

    int n_checks = 0;
    int n_fail = 0;
    int resp_cnt = 0;

    logic        q_pass [$];
    logic [63:0] q_fault [$];
    int          q_reads [$];
    string       q_req [$];

    always #4 clk = ~clk;

    tchk_top #(.ADDR_W(64), .TAG_AW(TAG_AW), .SIZE_W(SIZE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ptr(ptr), .size_m1(size_m1),
        .page_tagged(page_tagged), .tbi_en(tbi_en), .match_all_en(match_all_en),
        .tm_re(tm_re), .tm_addr(tm_addr), .tm_rdata(tm_rdata),
        .done(done), .pass(pass), .fault_addr(fault_addr)
    );

    always @(posedge clk) begin
        if (tm_re) tm_rdata <= tmem[tm_addr];
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [63:0] mkp(input logic [3:0] tag, input logic h,
                                        input logic [15:0] off);
        return (64'(tag) << 56) | (64'(h) << 55) | 64'(off);
    endfunction

    task automatic set_gran(input int g, input logic [3:0] v);
        if (g % 2 == 1) tmem[g/2][7:4] = v;
        else            tmem[g/2][3:0] = v;
    endtask

    function automatic void model(input logic [63:0] p, input int sz,
                                  input logic tg, input logic [1:0] tbi,
                                  input logic [1:0] ma, output logic ps,
                                  output logic [63:0] f, output int rd);
        logic       h;
        logic [3:0] t;
        logic [3:0] nib;
        logic [63:0] g0;
        logic [63:0] g1;
        h = p[55];
        t = p[59:56];
        ps = 1'b1;
        f = '0;
        rd = 0;
        if (!tbi[h]) return;
        if (ma[h] && t == (h ? 4'hF : 4'h0)) return;
        if (!tg) return;
        g0 = p >> 4;
        g1 = (p + 64'(sz)) >> 4;
        for (logic [63:0] g = g0; g <= g1; g++) begin
            nib = g[0] ? tmem[g[TAG_AW:1]][7:4] : tmem[g[TAG_AW:1]][3:0];
            rd = int'((g >> 1) - (g0 >> 1)) + 1;
            if (nib != t) begin
                ps = 1'b0;
                f = (g == g0) ? p : (g << 4);
                return;
            end
        end
    endfunction

    // Monitor: measures each check and compares it against the scoreboard
    int mon_busy = 0;
    int mon_cyc = 0;
    int mon_reads = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_busy == 0 && start) begin
                mon_busy = 1;
                mon_cyc = 0;
                mon_reads = tm_re ? 1 : 0;
            end else if (mon_busy == 1) begin
                mon_cyc++;
                if (tm_re) mon_reads++;
                if (done) begin
                    if (q_pass.size() == 0) begin
                        check("R12", "unexpected result", 64'd1, 64'd0);
                    end else begin
                        logic        ep;
                        logic [63:0] ef;
                        int          er;
                        string       rq;
                        ep = q_pass.pop_front();
                        ef = q_fault.pop_front();
                        er = q_reads.pop_front();
                        rq = q_req.pop_front();
                        check(rq, "pass", 64'(pass), 64'(ep));
                        check(rq, "fault_addr (R7)", fault_addr, ef);
                        check(rq, "read count (R2/R6)", 64'(mon_reads), 64'(er));
                        check(rq, "latency (R11)", 64'(mon_cyc), 64'(er + 1));
                    end
                    mon_busy = 0;
                    resp_cnt++;
                end
            end else if (done) begin
                check("R11", "done outside a check", 64'd1, 64'd0);
            end
        end
    end

    task automatic run(input string req, input logic [63:0] p, input int sz,
                       input logic tg, input logic [1:0] tbi, input logic [1:0] ma,
                       input bit extra);
        logic        ep;
        logic [63:0] ef;
        int          er;
        int          target;
        model(p, sz, tg, tbi, ma, ep, ef, er);
        q_pass.push_back(ep);
        q_fault.push_back(ef);
        q_reads.push_back(er);
        q_req.push_back(req);
        target = resp_cnt + 1;
        @(negedge clk);
        ptr = p; size_m1 = SIZE_W'(sz); page_tagged = tg;
        tbi_en = tbi; match_all_en = ma; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra) begin
            ptr = mkp(4'h3, 1'b0, 16'h0A00); page_tagged = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (resp_cnt == target);
        repeat (3) @(negedge clk);
        check(req, "scoreboard drained", 64'(q_pass.size()), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < (1 << TAG_AW); i++) tmem[i] = 8'h33;
        repeat (3) @(negedge clk);
        check("R1", "done after reset", 64'(done), 64'd0);
        check("R1", "pass after reset", 64'(pass), 64'd0);
        check("R1", "tm_re after reset", 64'(tm_re), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: single aligned granule
        run("R3", mkp(4'h3, 1'b0, 16'h0100), 15, 1'b1, 2'b11, 2'b00, 1'b0);
        // R4: aligned 256 bytes, 16 granules
        run("R4", mkp(4'h3, 1'b0, 16'h0200), 255, 1'b1, 2'b11, 2'b00, 1'b0);
        // R5: odd start spanning three granules
        run("R5", mkp(4'h3, 1'b0, 16'h0318), 31, 1'b1, 2'b11, 2'b00, 1'b0);
        // R7: first granule mismatch reports the pointer
        set_gran(16'h41, 4'h5);
        run("R7", mkp(4'h3, 1'b0, 16'h0418), 31, 1'b1, 2'b11, 2'b00, 1'b0);
        // R7: later granule mismatch reports the granule base
        set_gran(16'h53, 4'h9);
        run("R7", mkp(4'h3, 1'b0, 16'h0508), 63, 1'b1, 2'b11, 2'b00, 1'b0);
        // R3: mismatch in the high nibble only
        set_gran(16'h61, 4'h0);
        run("R3", mkp(4'h3, 1'b0, 16'h0600), 31, 1'b1, 2'b11, 2'b00, 1'b0);
        // R5: low nibble of first byte ignored on odd start
        set_gran(16'h70, 4'h0);
        run("R5", mkp(4'h3, 1'b0, 16'h0710), 15, 1'b1, 2'b11, 2'b00, 1'b0);
        // R4: 17 granules, mismatch just beyond the end
        set_gran(16'h91, 4'h0);
        run("R4", mkp(4'h3, 1'b0, 16'h0808), 255, 1'b1, 2'b11, 2'b00, 1'b0);
        // R6: two mismatches, only the first reported
        set_gran(16'hA2, 4'h1);
        set_gran(16'hA5, 4'h2);
        run("R6", mkp(4'h3, 1'b0, 16'h0A00), 255, 1'b1, 2'b11, 2'b00, 1'b0);
        // R8: untagged page passes despite mismatches
        run("R8", mkp(4'h3, 1'b0, 16'h0A00), 255, 1'b0, 2'b11, 2'b00, 1'b0);
        // R9: tagging off for upper half
        run("R9", mkp(4'h3, 1'b1, 16'h0A00), 255, 1'b1, 2'b01, 2'b00, 1'b0);
        // R9: lower half still checked with upper half off
        run("R9", mkp(4'h3, 1'b0, 16'h0A00), 255, 1'b1, 2'b01, 2'b00, 1'b0);
        // R10: match-all tag F in upper half
        run("R10", mkp(4'hF, 1'b1, 16'h0A00), 255, 1'b1, 2'b11, 2'b10, 1'b0);
        // R10: match-all tag 0 in lower half
        run("R10", mkp(4'h0, 1'b0, 16'h0A00), 255, 1'b1, 2'b11, 2'b01, 1'b0);
        // R10: tag F in lower half is not a match-all value
        run("R10", mkp(4'hF, 1'b0, 16'h0A00), 255, 1'b1, 2'b11, 2'b11, 1'b0);
        // R12: second start while busy is ignored
        run("R12", mkp(4'h3, 1'b0, 16'h0200), 255, 1'b1, 2'b11, 2'b00, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule